// File: doc/BRIEF.md
# Frame-aligned clock-crossing FIFO

This block moves received data words from a receive clock domain into a management/output clock domain through a small dual-port RAM. The read side takes one word on every output clock, so the block acts as an elastic slip buffer. Its purpose is to keep a fixed distance between the write and read pointers. That distance is reset to half the buffer depth each time the receive framer reports a new frame alignment. It is also reset when management software requests a pointer re-initialization.

After the receive-side reset, the write port walks every RAM location and writes zero. When that sweep ends, the block raises an initialization-done flag in the output domain. Receive data is only accepted after the sweep. The write pointer crosses to the read side as Gray code through two-flop synchronizers. Alignment requests cross as toggle signals, and the read pointer is re-centred from the synchronized write pointer.

Top module: `fa_cdc_fifo`

## Requirements
- R1: After receive reset, all DEPTH locations are written with zero. `init_done_o` rises between DEPTH and DEPTH+6 output clocks after both resets are released, and then stays high.
- R2: Words offered with `rx_clken_i` high before the zero sweep ends are discarded. Until the first accepted write, `data_o` reads only zero.
- R3: Once initialized, a word is stored and the write pointer advances only in receive cycles where `rx_clken_i` is high. A stall of k receive cycles shortens the write-to-read distance by exactly k words.
- R4: The read pointer advances by one location on every output clock, including while no writes occur (out of frame). `data_o` presents the addressed word one clock later.
- R5: A high `rx_nfa_i` sample restarts the write pointer at address 0. Within a bounded number of output clocks, the read pointer is re-centred to half the depth behind the synchronized write pointer. The resulting distance, measured as the offered word count minus `data_o`, lies between DEPTH/2 and DEPTH/2+8 and is the same after every re-alignment.
- R6: A pointer re-initialization request takes effect only on an output clock where `mg_we_i`, `mg_sel_i` and `mg_ptr_rst_i` are all high. It then triggers the same re-alignment as R5. With any of the three low, the pointer distance is unchanged.
- R7: With `rx_clken_i` held high and equal clock rates, `data_o` reproduces the written word stream in order, with no loss or repetition.
- R8: While the resets are asserted, `data_o` is zero and `init_done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk_i | input | 1 | Receive-domain clock |
| rx_rst_ni | input | 1 | Receive-domain active-low asynchronous reset |
| rx_data_i | input | DW | Received data word |
| rx_nfa_i | input | 1 | New frame alignment strobe |
| rx_clken_i | input | 1 | Receive clock enable; qualifies each incoming word |
| mg_clk_i | input | 1 | Management/output clock (read side) |
| mg_rst_ni | input | 1 | Management-domain active-low asynchronous reset |
| mg_we_i | input | 1 | Management write enable |
| mg_sel_i | input | 1 | Block select from the address decoder |
| mg_ptr_rst_i | input | 1 | Pointer re-initialization control bit |
| data_o | output | DW | Data word read from the FIFO |
| init_done_o | output | 1 | RAM zero sweep complete, synchronized to output clock |

## Verification
The bench builds the block with DW = 12 and DEPTH = 32, so re-centring puts the reader 16 words behind the writer. With that spacing, stalls of up to eight receive cycles leave enough margin that the stream stays continuous and each stall shows up as an exact change in distance. Both clocks run at the same rate with a fixed 3 ns skew, so the distance after every re-alignment is one repeatable number. That number can be compared across the frame-alignment path and the management path. The 12-bit counter payload keeps every offered word distinct across the whole run, which makes a lost or repeated word visible.

// File: rtl/fa_fifo_pkg.sv
`timescale 1ns/1ps
package fa_fifo_pkg;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/fa_sync.sv
`timescale 1ns/1ps
module fa_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/fa_ram.sv
`timescale 1ns/1ps
module fa_ram #(
  parameter  int DW    = 16,
  parameter  int DEPTH = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rclk_i,
  input  logic          rrst_ni,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rrst_ni) begin
    if (!rrst_ni) rdata_o <= '0;
    else          rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/fa_wr_ctrl.sv
`timescale 1ns/1ps
module fa_wr_ctrl
  import fa_fifo_pkg::*;
#(
  parameter  int DW    = 16,
  parameter  int DEPTH = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] data_i,
  input  logic          ce_i,
  input  logic          nfa_i,
  input  logic          mreq_tgl_i,   // async, from management domain
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o,
  output logic [AW-1:0] wgray_o,
  output logic          align_tgl_o,
  output logic          done_o
);
  logic [AW-1:0] wptr_q, wptr_d, clr_q, wgray_q;
  logic          done_q, tgl_q, mreq_s, mreq_d, align;

  fa_sync #(.W(1)) u_mreq_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (mreq_tgl_i),
    .q_o   (mreq_s)
  );

  // Management request behaves as a frame alignment once the sweep is done
  assign align = done_q & (nfa_i | (mreq_s ^ mreq_d));

  always_comb begin
    wptr_d = wptr_q;
    if (!done_q)    wptr_d = '0;
    else if (align) wptr_d = ce_i ? AW'(1) : '0;
    else if (ce_i)  wptr_d = wptr_q + AW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      wgray_q <= '0;
      clr_q   <= '0;
      done_q  <= 1'b0;
      tgl_q   <= 1'b0;
      mreq_d  <= 1'b0;
    end else begin
      mreq_d  <= mreq_s;
      wptr_q  <= wptr_d;
      wgray_q <= AW'(bin2gray(32'(wptr_d)));
      if (!done_q) begin
        clr_q <= clr_q + AW'(1);
        if (clr_q == AW'(DEPTH - 1)) begin
          done_q <= 1'b1;
          tgl_q  <= ~tgl_q;    // end of sweep counts as first alignment
        end
      end else if (align) begin
        tgl_q <= ~tgl_q;
      end
    end
  end

  assign we_o        = !done_q || ce_i;
  assign waddr_o     = !done_q ? clr_q : (align ? '0 : wptr_q);
  assign wdata_o     = done_q ? data_i : '0;
  assign wgray_o     = wgray_q;
  assign align_tgl_o = tgl_q;
  assign done_o      = done_q;

  p_sweep_ends_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_q && clr_q == AW'(DEPTH - 1)) |=> done_q);

  p_done_sticky_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> done_q);

  p_idle_holds_ptr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !align && !ce_i) |=> wptr_q == $past(wptr_q));

  p_align_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && align) |=> wptr_q <= AW'(1));
endmodule

// File: rtl/fa_rd_ctrl.sv
`timescale 1ns/1ps
module fa_rd_ctrl
  import fa_fifo_pkg::*;
#(
  parameter  int DEPTH = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int HALF  = DEPTH / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] wgray_i,     // async, from receive domain
  input  logic          align_tgl_i, // async, from receive domain
  output logic [AW-1:0] raddr_o
);
  logic [AW-1:0] wgray_s, rptr_q;
  logic          tgl_s, tgl_d, realign_q;

  fa_sync #(.W(AW)) u_wptr_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (wgray_i),
    .q_o   (wgray_s)
  );

  fa_sync #(.W(1)) u_tgl_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (align_tgl_i),
    .q_o   (tgl_s)
  );

  // One extra stage lets a multi-bit pointer jump settle before use
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgl_d     <= 1'b0;
      realign_q <= 1'b0;
      rptr_q    <= '0;
    end else begin
      tgl_d     <= tgl_s;
      realign_q <= tgl_s ^ tgl_d;
      if (realign_q) rptr_q <= AW'(gray2bin(32'(wgray_s))) - AW'(HALF);
      else           rptr_q <= rptr_q + AW'(1);
    end
  end

  assign raddr_o = rptr_q;

  p_rptr_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !realign_q |=> rptr_q == $past(rptr_q) + AW'(1));
endmodule

// File: rtl/fa_cdc_fifo.sv
`timescale 1ns/1ps
module fa_cdc_fifo #(
  parameter  int DW    = 16,
  parameter  int DEPTH = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          rx_clk_i,
  input  logic          rx_rst_ni,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_nfa_i,
  input  logic          rx_clken_i,
  input  logic          mg_clk_i,
  input  logic          mg_rst_ni,
  input  logic          mg_we_i,
  input  logic          mg_sel_i,
  input  logic          mg_ptr_rst_i,
  output logic [DW-1:0] data_o,
  output logic          init_done_o
);
  logic          req_tgl_q, we, align_tgl, wr_done;
  logic [AW-1:0] waddr, raddr, wgray;
  logic [DW-1:0] wdata;

  always_ff @(posedge mg_clk_i or negedge mg_rst_ni) begin
    if (!mg_rst_ni)                               req_tgl_q <= 1'b0;
    else if (mg_we_i && mg_sel_i && mg_ptr_rst_i) req_tgl_q <= ~req_tgl_q;
  end

  fa_wr_ctrl #(.DW(DW), .DEPTH(DEPTH)) u_wr (
    .clk_i      (rx_clk_i),
    .rst_ni     (rx_rst_ni),
    .data_i     (rx_data_i),
    .ce_i       (rx_clken_i),
    .nfa_i      (rx_nfa_i),
    .mreq_tgl_i (req_tgl_q),
    .we_o       (we),
    .waddr_o    (waddr),
    .wdata_o    (wdata),
    .wgray_o    (wgray),
    .align_tgl_o(align_tgl),
    .done_o     (wr_done)
  );

  fa_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .clk_i      (mg_clk_i),
    .rst_ni     (mg_rst_ni),
    .wgray_i    (wgray),
    .align_tgl_i(align_tgl),
    .raddr_o    (raddr)
  );

  fa_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .wclk_i (rx_clk_i),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(wdata),
    .rclk_i (mg_clk_i),
    .rrst_ni(mg_rst_ni),
    .raddr_i(raddr),
    .rdata_o(data_o)
  );

  fa_sync #(.W(1)) u_done_sync (
    .clk_i (mg_clk_i),
    .rst_ni(mg_rst_ni),
    .d_i   (wr_done),
    .q_o   (init_done_o)
  );

  p_req_qualified_r6: assert property (@(posedge mg_clk_i) disable iff (!mg_rst_ni)
    (req_tgl_q != $past(req_tgl_q)) |-> $past(mg_we_i && mg_sel_i && mg_ptr_rst_i));

  p_init_flag_sticky_r1: assert property (@(posedge mg_clk_i) disable iff (!mg_rst_ni)
    init_done_o |=> init_done_o);
endmodule

// File: tb/tb_fa_cdc_fifo.sv
`timescale 1ns/1ps
module tb_fa_cdc_fifo;
  localparam int DW    = 12;
  localparam int DEPTH = 32;
  localparam int HALF  = DEPTH / 2;

  logic          rx_clk = 1'b0, mg_clk = 1'b0;
  logic          rx_rst_n = 1'b0, mg_rst_n = 1'b0;
  logic [DW-1:0] rx_data = 12'h5A0;
  logic          rx_nfa = 1'b0, rx_clken = 1'b0;
  logic          mg_we = 1'b0, mg_sel = 1'b0, mg_ptr = 1'b0;
  logic [DW-1:0] data_o;
  logic          init_done_o;

  int  n_chk = 0, n_fail = 0;
  bit  ce_base = 1'b1;
  int  stall_left = 0;
  bit  nfa_req = 1'b0;
  bit  mon_on = 1'b0, mon_first = 1'b1;
  logic [DW-1:0] mon_prev;
  int  nom;

  fa_cdc_fifo #(.DW(DW), .DEPTH(DEPTH)) dut (
    .rx_clk_i    (rx_clk),
    .rx_rst_ni   (rx_rst_n),
    .rx_data_i   (rx_data),
    .rx_nfa_i    (rx_nfa),
    .rx_clken_i  (rx_clken),
    .mg_clk_i    (mg_clk),
    .mg_rst_ni   (mg_rst_n),
    .mg_we_i     (mg_we),
    .mg_sel_i    (mg_sel),
    .mg_ptr_rst_i(mg_ptr),
    .data_o      (data_o),
    .init_done_o (init_done_o)
  );

  always #4 rx_clk = ~rx_clk;
  initial begin
    #3;
    forever #4 mg_clk = ~mg_clk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lag();
    logic [DW-1:0] d;
    d = rx_data - data_o;
    return int'(d);
  endfunction

  // Receive-side driver: counter payload, stalls and alignment strobes
  always @(negedge rx_clk) begin
    rx_nfa = nfa_req;
    nfa_req = 1'b0;
    if (stall_left > 0) begin
      rx_clken = 1'b0;
      stall_left--;
    end else begin
      rx_clken = ce_base;
      if (ce_base) rx_data = rx_data + 1'b1;
    end
  end

  // R7 / R4: stream continuity monitor
  always @(negedge mg_clk) begin
    if (mon_on) begin
      if (mon_first) mon_first = 1'b0;
      else chk(data_o == mon_prev + 1'b1, "R7 stream order", int'(data_o), int'(mon_prev + 1'b1));
      mon_prev = data_o;
    end
  end

  task automatic mg_wait(input int n);
    repeat (n) @(negedge mg_clk);
  endtask

  task automatic mg_req(input bit we, input bit sel, input bit bitv);
    @(negedge mg_clk);
    mg_we = we; mg_sel = sel; mg_ptr = bitv;
    @(negedge mg_clk);
    mg_we = 1'b0; mg_sel = 1'b0; mg_ptr = 1'b0;
  endtask

  task automatic stall_and_check(input int k);
    @(negedge mg_clk);
    stall_left = k;
    mg_wait(DEPTH);
    chk(lag() == nom - k, "R3 stall shortens distance", lag(), nom - k);
  endtask

  task automatic realign(input int how, input int k);
    // how: 0 frame strobe, 1 qualified mgmt, 2 no select, 3 no write, 4 bit low
    if (how <= 1) begin
      mon_on = 1'b0;
      if (how == 0) begin @(negedge mg_clk); nfa_req = 1'b1; end
      else mg_req(1'b1, 1'b1, 1'b1);
      mg_wait(3 * DEPTH);
      chk(lag() == nom, how == 0 ? "R5 frame realign" : "R6 mgmt realign", lag(), nom);
      mon_first = 1'b1;
      mon_on = 1'b1;
    end else begin
      if (how == 2)      mg_req(1'b1, 1'b0, 1'b1);
      else if (how == 3) mg_req(1'b0, 1'b1, 1'b1);
      else               mg_req(1'b1, 1'b1, 1'b0);
      mg_wait(3 * DEPTH);
      chk(lag() == nom - k, "R6 unqualified request ignored", lag(), nom - k);
    end
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cnt, nz, k, seed;
    seed = 32'h1A2B;
    void'($urandom(seed));

    // R8: reset state
    mg_wait(3);
    chk(data_o == '0, "R8 data during reset", int'(data_o), 0);
    chk(init_done_o == 1'b0, "R8 flag during reset", int'(init_done_o), 0);

    // R1 / R2: sweep timing, words offered during sweep discarded
    @(negedge rx_clk);
    rx_rst_n = 1'b1;
    mg_rst_n = 1'b1;
    cnt = 0;
    while (!init_done_o && cnt < 200) begin
      @(negedge mg_clk);
      cnt++;
      if (cnt == HALF) ce_base = 1'b0;
    end
    chk(cnt >= DEPTH && cnt <= DEPTH + 6, "R1 init done latency", cnt, DEPTH);
    nz = 0;
    for (int i = 0; i < 2 * DEPTH + 8; i++) begin
      @(negedge mg_clk);
      if (data_o != '0) nz++;
      if (!init_done_o) nz++;
    end
    chk(nz == 0, "R2 zero fill, early words discarded", nz, 0);

    // R5: first alignment with data flowing
    @(negedge mg_clk);
    ce_base = 1'b1;
    nfa_req = 1'b1;
    mg_wait(3 * DEPTH);
    nom = lag();
    chk(nom >= HALF && nom <= HALF + 8, "R5 half-depth distance", nom, HALF);
    mon_first = 1'b1;
    mon_on = 1'b1;
    mg_wait(DEPTH);
    chk(lag() == nom, "R7 steady distance", lag(), nom);

    // Directed: each request path after a stall
    stall_and_check(5);
    realign(2, 5);
    realign(3, 5);
    realign(4, 5);
    realign(1, 5);
    stall_and_check(8);
    realign(0, 8);
    stall_and_check(1);
    realign(1, 1);

    // Constrained random mix
    for (int it = 0; it < 10; it++) begin
      k = 1 + int'($urandom % 8);
      stall_and_check(k);
      realign(int'($urandom % 5), k);
      if (lag() != nom) realign(0, k);
    end

    mon_on = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule